// File: doc/BRIEF.md
# Isochronous Rate Feedback Generator

This block produces the rate-feedback word that an isochronous sink returns to its host. A free-running 16-bit counter advances with the line clock. Each time a feedback request arrives, the block samples that counter and takes the wrapped difference from the sample taken at the previous request. That difference is the measured number of line ticks per feedback interval.

A measurement outside a plausible window is discarded, and the nominal rate is used in its place. The result is then moved by a fixed step according to how full the transmit buffer is. When the buffer is running low, the host is asked for more data. When it is running high, the host is asked for less.

The word appears one clock after the request with a single-cycle valid strobe. It is held until the next request. Only its low three bytes carry information.

Top module: `rate_fb_gen`

## Requirements
- R1: On a request, the measured delta is (tick_cnt − previous sample) modulo 65536, so a counter wrap between two requests yields the true forward distance.
- R2: The stored sample takes the value of tick_cnt on every request, including requests whose delta is rejected. After reset the stored sample is 0.
- R3: A delta from 7168 to 9216 inclusive is kept. A delta below 7168 or above 9216 is replaced by 8192.
- R4: When fill_lvl is below 48, 256 is added to the value chosen under R3.
- R5: When fill_lvl is above 128, 256 is subtracted from the value chosen under R3. For fill levels 48 to 128 inclusive, the value is passed unchanged.
- R6: fb_valid is high for exactly the one cycle that follows a cycle with req high, and is low otherwise.
- R7: Between requests, fb_word holds its last value. Changes on tick_cnt and fill_lvl while req is low affect neither fb_word nor the stored sample.
- R8: Bits 31:24 of fb_word are always zero, so the value fits in three bytes.
- R9: While rst_n is low and in the first cycle after reset, fb_valid is 0 and fb_word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Feedback request, one cycle per request |
| tick_cnt | input | 16 | Free-running line-tick counter |
| fill_lvl | input | 8 | Transmit buffer fill level in frames |
| fb_word | output | 32 | Feedback value, held between requests |
| fb_valid | output | 1 | Strobe marking a new fb_word |

## Verification
The checker runs on every cycle and covers the following behaviour:
- the strobe's timing relative to req;
- that fb_word holds between requests;
- that the upper byte stays zero;
- that every emitted word lies inside the window widened by one step;
- that a low or high fill level bounds the word from the proper side.

The checker cannot tell whether the exact arithmetic is right, so that is left to the bench's vector walk. This includes the 16-bit wrap, the inclusive window edges, the threshold edges at 48 and 128, the nominal fallback, and the fact that a rejected sample still becomes the reference. The same applies to a reset in mid-run clearing the stored sample: only a following request can reveal that.

// File: rtl/rate_fb_gen.sv
module rate_fb_gen #(
  parameter int TICK_W   = 16,
  parameter int LVL_W    = 8,
  parameter int OUT_W    = 32,
  parameter int NOMINAL  = 8192,
  parameter int RATE_MIN = 7168,
  parameter int RATE_MAX = 9216,
  parameter int LVL_LOW  = 48,
  parameter int LVL_HIGH = 128,
  parameter int STEP     = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [TICK_W-1:0] tick_cnt,
  input  logic [LVL_W-1:0]  fill_lvl,
  output logic [OUT_W-1:0]  fb_word,
  output logic              fb_valid
);

  localparam logic [TICK_W-1:0] MIN_T  = TICK_W'(RATE_MIN);
  localparam logic [TICK_W-1:0] MAX_T  = TICK_W'(RATE_MAX);
  localparam logic [OUT_W-1:0]  NOM_O  = OUT_W'(NOMINAL);
  localparam logic [OUT_W-1:0]  STEP_O = OUT_W'(STEP);
  localparam logic [LVL_W-1:0]  LOW_L  = LVL_W'(LVL_LOW);
  localparam logic [LVL_W-1:0]  HIGH_L = LVL_W'(LVL_HIGH);

  logic [TICK_W-1:0] prev_q;
  logic [TICK_W-1:0] delta;
  logic              in_win;
  logic [OUT_W-1:0]  base;
  logic [OUT_W-1:0]  nxt;

  assign delta  = tick_cnt - prev_q;
  assign in_win = (delta >= MIN_T) && (delta <= MAX_T);
  assign base   = in_win ? OUT_W'(delta) : NOM_O;
  assign nxt    = (fill_lvl < LOW_L)  ? base + STEP_O :
                  (fill_lvl > HIGH_L) ? base - STEP_O : base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= '0;
      fb_word  <= '0;
      fb_valid <= 1'b0;
    end else begin
      fb_valid <= req;
      if (req) begin
        prev_q  <= tick_cnt;
        fb_word <= nxt;
      end
    end
  end

endmodule

module rate_fb_gen_chk #(
  parameter int TICK_W   = 16,
  parameter int LVL_W    = 8,
  parameter int OUT_W    = 32,
  parameter int RATE_MIN = 7168,
  parameter int RATE_MAX = 9216,
  parameter int LVL_LOW  = 48,
  parameter int LVL_HIGH = 128,
  parameter int STEP     = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic [LVL_W-1:0]  fill_lvl,
  input logic [OUT_W-1:0]  fb_word,
  input logic              fb_valid
);
  localparam logic [OUT_W-1:0] LO_O   = OUT_W'(RATE_MIN - STEP);
  localparam logic [OUT_W-1:0] HI_O   = OUT_W'(RATE_MAX + STEP);
  localparam logic [OUT_W-1:0] LOB_O  = OUT_W'(RATE_MIN + STEP);
  localparam logic [OUT_W-1:0] HIB_O  = OUT_W'(RATE_MAX - STEP);
  localparam logic [LVL_W-1:0] LOW_L  = LVL_W'(LVL_LOW);
  localparam logic [LVL_W-1:0] HIGH_L = LVL_W'(LVL_HIGH);

  a_r6_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> fb_valid);
  a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !fb_valid);
  a_r7_hold_between_req: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable(fb_word));
  a_r8_upper_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fb_word[OUT_W-1:24] == '0);
  a_r3_word_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid |-> (fb_word >= LO_O && fb_word <= HI_O));
  a_r4_low_fill_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (req && fill_lvl < LOW_L) |=> fb_word >= LOB_O);
  a_r5_high_fill_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (req && fill_lvl > HIGH_L) |=> fb_word <= HIB_O);
endmodule

bind rate_fb_gen rate_fb_gen_chk #(
  .TICK_W(TICK_W), .LVL_W(LVL_W), .OUT_W(OUT_W), .RATE_MIN(RATE_MIN),
  .RATE_MAX(RATE_MAX), .LVL_LOW(LVL_LOW), .LVL_HIGH(LVL_HIGH), .STEP(STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .fill_lvl(fill_lvl),
  .fb_word(fb_word), .fb_valid(fb_valid)
);

// File: tb/rate_fb_gen_tb.sv
module rate_fb_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [15:0] tick_cnt = '0;
  logic [7:0]  fill_lvl = '0;
  logic [31:0] fb_word;
  logic        fb_valid;
  int total = 0;
  int bad = 0;

  rate_fb_gen u_dut (.clk(clk), .rst_n(rst_n), .req(req), .tick_cnt(tick_cnt),
                     .fill_lvl(fill_lvl), .fb_word(fb_word), .fb_valid(fb_valid));

  always #5 clk = ~clk;

  localparam int NV = 10;
  localparam int VT [NV] = '{8192, 16484, 23652, 32868, 40035, 49252, 57252, 216, 316, 64852};
  localparam int VF [NV] = '{100, 100, 47, 129, 48, 128, 200, 0, 255, 10};
  localparam int VE [NV] = '{8192, 8292, 7424, 8960, 8192, 8192, 7744, 8756, 7936, 8448};
  localparam string VR [NV] = '{"R1", "R1", "R3 R4", "R3 R5", "R3 R4", "R2 R5",
                                "R5", "R1 R4", "R3 R5", "R2 R4"};

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic request(input int t, input int f, input string r, input int exp);
    @(negedge clk);
    tick_cnt = 16'(t); fill_lvl = 8'(f); req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check({r, " R6 valid"}, 32'(fb_valid), 32'd1);
    check(r, fb_word, 32'(exp));
    check("R8 upper byte", {24'd0, fb_word[31:24]}, 32'd0);
    @(negedge clk);
    check("R6 single pulse", 32'(fb_valid), 32'd0);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset valid", 32'(fb_valid), 32'd0);
    check("R9 reset word", fb_word, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset valid", 32'(fb_valid), 32'd0);
    check("R9 after reset word", fb_word, 32'd0);

    for (int i = 0; i < NV; i++) request(VT[i], VF[i], VR[i], VE[i]);

    // R7: no request, inputs wander, output holds, reference unchanged
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      tick_cnt = 16'(1000 * k + 5); fill_lvl = 8'(60 * k);
    end
    @(negedge clk);
    check("R7 hold word", fb_word, 32'd8448);
    check("R7 no valid", 32'(fb_valid), 32'd0);
    request(64852 + 8000, 90, "R7 reference kept", 8000);

    // R2: reset in mid-run clears the stored sample to 0
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R9 mid reset word", fb_word, 32'd0);
    request(7500, 60, "R2 reset sample", 7500);
    request(7500 + 9216, 128, "R3 upper edge", 9216);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule